// File: doc/BRIEF.md
# Video Memory Access and Mirroring Unit

This block connects a processor bus to three on-chip graphics memories: a video RAM, a colour palette RAM and a sprite attribute RAM. It accepts one write and one read request per cycle. Each request names the target memory, a transfer size (byte, halfword or word) and a byte address. The block folds the address into the physical array using each memory's aliasing rules, lays the data out little-endian, and returns read data one cycle after the request.

Byte-sized writes follow special rules. In the palette and the video RAM, a byte write is widened into a halfword write, and the byte value fills both halves. In the sprite attribute RAM a byte write is thrown away. In the video RAM it is also thrown away when it lands in the sprite-pattern area. Where that area starts depends on the current background mode. The block also presents the palette's first halfword continuously, as the backdrop colour.

Sizes are set by parameters. `VID_AW` is the video alias window in address bits; the full-size memory uses 17, which gives 96 KiB in a 128 KiB window. `PAL_AW` and `OBJ_AW` set the palette and attribute windows; 10 bits gives 1 KiB each. The defaults keep the video array small.

Top module: `vmem_access_unit`

## Requirements
- R1: While `rst` is high and after it falls, `rd_valid` is 0 and `backdrop` is 0 until a palette write changes it.
- R2: A read accepted with `rd_en` high at clock edge N drives `rd_valid` high with its data after edge N; `rd_valid` is low after any edge where `rd_en` was low.
- R3: Region code 0 selects video RAM, 1 palette, 2 attribute RAM, and 3 no memory. Region 3 reads return 0 and region 3 writes change nothing. Size code 0 is byte, 1 halfword, and 2 or 3 word. A byte read returns the byte at the mapped index, zero-extended. A halfword read returns the halfword at the index with bit 0 cleared. A word read returns the word at the index with bits 1:0 cleared. All are little-endian.
- R4: A video address is reduced to its low `VID_AW` bits. If both of the top two of those bits are 1, bit `VID_AW-2` is cleared. The last quarter of the window therefore aliases the quarter below it, and the array holds 3·2^(VID_AW-2) bytes.
- R5: Palette and attribute addresses use only their low `PAL_AW` and `OBJ_AW` bits respectively.
- R6: A byte write to the palette or the video RAM (when not dropped under R8) stores the byte into both bytes of the halfword at the index with bit 0 cleared. The other two bytes of the word are left unchanged.
- R7: Byte writes to the attribute RAM leave it unchanged. Halfword and word writes to it are stored.
- R8: A video byte write is dropped when its mapped index is at or above 2^(VID_AW-1) and `bg_mode` is 0, 1 or 2. For `bg_mode` 3 to 7 the limit is 2^(VID_AW-1)+2^(VID_AW-3). Byte writes below the limit are stored. Halfword and word writes are never dropped by mode.
- R9: A read and a write to the same location in the same cycle return the data held before the write.
- R10: `backdrop` equals palette bytes 1:0 (byte 1 in the upper half). It updates the cycle after any write that touches those bytes, including writes through aliased addresses, and is otherwise stable.
- R11: A halfword write stores 16 bits at the index with bit 0 cleared. A word write stores 32 bits at the index with bits 1:0 cleared. Both are little-endian.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_region | input | 2 | Write target memory code |
| wr_size | input | 2 | Write size code |
| wr_addr | input | 32 | Write byte address |
| wr_data | input | 32 | Write data, right-aligned |
| bg_mode | input | 3 | Background mode; selects the video byte-write limit |
| rd_en | input | 1 | Read request |
| rd_region | input | 2 | Read target memory code |
| rd_size | input | 2 | Read size code |
| rd_addr | input | 32 | Read byte address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data, zero-extended to 32 bits |
| backdrop | output | 16 | Palette halfword 0 |

## Verification
A write and a read can hit the same location in the same cycle, possibly through different alias addresses. The read must then return the older contents, while the write lands for the following cycle. The bench provokes this in a directed case and in random traffic, where a quarter of the reads copy the write's region and address. It judges every read against a byte-level reference model that takes the read result before it applies the write. The same model also predicts `backdrop` after every cycle.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

  typedef enum logic [1:0] {
    REG_VIDEO   = 2'd0,
    REG_PALETTE = 2'd1,
    REG_OBJECT  = 2'd2,
    REG_NONE    = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  // Byte lanes touched by a write; byte writes widen to a halfword
  function automatic logic [3:0] lane_mask(size_e sz, logic [1:0] off);
    case (sz)
      SZ_BYTE, SZ_HALF: return off[1] ? 4'b1100 : 4'b0011;
      default:          return 4'b1111;
    endcase
  endfunction

  // Replicate right-aligned write data across the word
  function automatic logic [31:0] spread(size_e sz, logic [31:0] d);
    case (sz)
      SZ_BYTE: return {4{d[7:0]}};
      SZ_HALF: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/vmem_addr_map.sv
module vmem_addr_map
  import vmem_pkg::*;
#(
  parameter int VID_AW = 12,
  parameter int PAL_AW = 10,
  parameter int OBJ_AW = 10
) (
  input  logic [31:0]       addr,
  output logic [VID_AW-3:0] vid_word,
  output logic [PAL_AW-3:0] pal_word,
  output logic [OBJ_AW-3:0] obj_word,
  output logic [1:0]        off
);
  localparam int VID_WW = VID_AW - 2;
  localparam int PAL_WW = PAL_AW - 2;
  localparam int OBJ_WW = OBJ_AW - 2;

  logic [VID_AW-1:0] vid_fold;

  always_comb begin
    vid_fold = VID_AW'(addr);
    // top quarter of the window folds onto the quarter below it
    if (vid_fold[VID_AW-1] && vid_fold[VID_AW-2]) vid_fold[VID_AW-2] = 1'b0;
    vid_word = VID_WW'(vid_fold >> 2);
    pal_word = PAL_WW'(addr >> 2);
    obj_word = OBJ_WW'(addr >> 2);
    off      = 2'(addr);
  end

endmodule

// File: rtl/vmem_write_gate.sv
module vmem_write_gate
  import vmem_pkg::*;
#(
  parameter int VID_WW = 10
) (
  input  region_e           region,
  input  size_e             size,
  input  logic [1:0]        off,
  input  logic [VID_WW-1:0] vid_word,
  input  logic [2:0]        bg_mode,
  input  logic [31:0]       data,
  output logic              drop,
  output logic [3:0]        be,
  output logic [31:0]       wdata
);
  // limits expressed in word units
  localparam logic [VID_WW:0] LIM_TILE = (VID_WW+1)'(2 ** (VID_WW - 1));
  localparam logic [VID_WW:0] LIM_BMP  = (VID_WW+1)'(2 ** (VID_WW - 1) + 2 ** (VID_WW - 3));

  logic [VID_WW:0] lim;

  always_comb begin
    lim   = (bg_mode <= 3'd2) ? LIM_TILE : LIM_BMP;
    drop  = (size == SZ_BYTE) &&
            ((region == REG_OBJECT) ||
             ((region == REG_VIDEO) && ({1'b0, vid_word} >= lim)));
    be    = lane_mask(size, off);
    wdata = spread(size, data);
  end

endmodule

// File: rtl/vmem_bank.sv
module vmem_bank #(
  parameter int DEPTH = 256,
  parameter int IW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [3:0]    be,
  input  logic [31:0]   wd,
  input  logic          re,
  input  logic [IW-1:0] ra,
  output logic [31:0]   rq
);
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (we && be[l]) mem[wa] <= wd[l*8 +: 8];
      if (re) q <= mem[ra];
    end

    assign rq[l*8 +: 8] = q;
  end

endmodule

// File: rtl/vmem_rd_align.sv
module vmem_rd_align
  import vmem_pkg::*;
(
  input  logic [31:0] word,
  input  size_e       size,
  input  logic [1:0]  off,
  output logic [31:0] data
);
  always_comb begin
    case (size)
      SZ_BYTE: data = 32'(8'(word >> {off, 3'b000}));
      SZ_HALF: data = off[1] ? {16'h0, word[31:16]} : {16'h0, word[15:0]};
      default: data = word;
    endcase
  end

endmodule

// File: rtl/vmem_access_unit.sv
module vmem_access_unit
  import vmem_pkg::*;
#(
  parameter int VID_AW = 12,
  parameter int PAL_AW = 10,
  parameter int OBJ_AW = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_region,
  input  logic [1:0]  wr_size,
  input  logic [31:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  bg_mode,
  input  logic        rd_en,
  input  logic [1:0]  rd_region,
  input  logic [1:0]  rd_size,
  input  logic [31:0] rd_addr,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic [15:0] backdrop
);
  localparam int VID_WW    = VID_AW - 2;
  localparam int PAL_WW    = PAL_AW - 2;
  localparam int OBJ_WW    = OBJ_AW - 2;
  localparam int VID_DEPTH = 3 * (2 ** (VID_AW - 4));
  localparam int PAL_DEPTH = 2 ** PAL_WW;
  localparam int OBJ_DEPTH = 2 ** OBJ_WW;

  region_e wreg, rreg, rreg_q;
  size_e   wsz, rsz, rsz_q;
  assign wreg = region_e'(wr_region);
  assign wsz  = size_e'(wr_size);
  assign rreg = region_e'(rd_region);
  assign rsz  = size_e'(rd_size);

  // write side
  logic [VID_WW-1:0] vid_wword, vid_rword;
  logic [PAL_WW-1:0] pal_wword, pal_rword;
  logic [OBJ_WW-1:0] obj_wword, obj_rword;
  logic [1:0]        woff, roff, roff_q;
  logic              wdrop;
  logic [3:0]        wbe;
  logic [31:0]       wsp;

  vmem_addr_map #(.VID_AW(VID_AW), .PAL_AW(PAL_AW), .OBJ_AW(OBJ_AW)) i_wmap (
    .addr(wr_addr), .vid_word(vid_wword), .pal_word(pal_wword),
    .obj_word(obj_wword), .off(woff)
  );

  vmem_write_gate #(.VID_WW(VID_WW)) i_gate (
    .region(wreg), .size(wsz), .off(woff), .vid_word(vid_wword),
    .bg_mode(bg_mode), .data(wr_data), .drop(wdrop), .be(wbe), .wdata(wsp)
  );

  // read side
  vmem_addr_map #(.VID_AW(VID_AW), .PAL_AW(PAL_AW), .OBJ_AW(OBJ_AW)) i_rmap (
    .addr(rd_addr), .vid_word(vid_rword), .pal_word(pal_rword),
    .obj_word(obj_rword), .off(roff)
  );

  logic vid_we, pal_we, obj_we;
  logic vid_re, pal_re, obj_re;
  assign vid_we = wr_en && (wreg == REG_VIDEO)   && !wdrop;
  assign pal_we = wr_en && (wreg == REG_PALETTE) && !wdrop;
  assign obj_we = wr_en && (wreg == REG_OBJECT)  && !wdrop;
  assign vid_re = rd_en && (rreg == REG_VIDEO);
  assign pal_re = rd_en && (rreg == REG_PALETTE);
  assign obj_re = rd_en && (rreg == REG_OBJECT);

  logic [31:0] vid_q, pal_q, obj_q;

  vmem_bank #(.DEPTH(VID_DEPTH), .IW(VID_WW)) i_vid (
    .clk(clk), .we(vid_we), .wa(vid_wword), .be(wbe), .wd(wsp),
    .re(vid_re), .ra(vid_rword), .rq(vid_q)
  );
  vmem_bank #(.DEPTH(PAL_DEPTH), .IW(PAL_WW)) i_pal (
    .clk(clk), .we(pal_we), .wa(pal_wword), .be(wbe), .wd(wsp),
    .re(pal_re), .ra(pal_rword), .rq(pal_q)
  );
  vmem_bank #(.DEPTH(OBJ_DEPTH), .IW(OBJ_WW)) i_obj (
    .clk(clk), .we(obj_we), .wa(obj_wword), .be(wbe), .wd(wsp),
    .re(obj_re), .ra(obj_rword), .rq(obj_q)
  );

  // read pipeline
  logic rd_valid_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      rreg_q     <= REG_NONE;
      rsz_q      <= SZ_WORD;
      roff_q     <= 2'd0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) begin
        rreg_q <= rreg;
        rsz_q  <= rsz;
        roff_q <= roff;
      end
    end
  end

  logic [31:0] rword;
  always_comb begin
    case (rreg_q)
      REG_VIDEO:   rword = vid_q;
      REG_PALETTE: rword = pal_q;
      REG_OBJECT:  rword = obj_q;
      default:     rword = 32'h0;
    endcase
  end

  vmem_rd_align i_align (.word(rword), .size(rsz_q), .off(roff_q), .data(rd_data));
  assign rd_valid = rd_valid_q;

  // backdrop shadow of palette halfword 0
  logic [15:0] backdrop_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      backdrop_q <= 16'h0;
    end else if (pal_we && (pal_wword == '0)) begin
      if (wbe[0]) backdrop_q[7:0]  <= wsp[7:0];
      if (wbe[1]) backdrop_q[15:8] <= wsp[15:8];
    end
  end
  assign backdrop = backdrop_q;

  // R2: read data valid exactly one cycle after a request
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R7: no byte write ever reaches the attribute array
  assert_obj_byte_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    obj_we |-> (wsz != SZ_BYTE));

  // R8: video byte writes reaching the array lie below the mode limit
  assert_vid_byte_limit_R8: assert property (@(posedge clk) disable iff (rst)
    (vid_we && (wsz == SZ_BYTE)) |->
      ((bg_mode <= 3'd2) ? (int'(vid_wword) < 2 ** (VID_WW - 1))
                         : (int'(vid_wword) < 2 ** (VID_WW - 1) + 2 ** (VID_WW - 3))));

  // R4: folded video index stays inside the physical array
  assert_vid_alias_range_R4: assert property (@(posedge clk) disable iff (rst)
    (vid_we || vid_re) |-> ((int'(vid_wword) < VID_DEPTH) && (int'(vid_rword) < VID_DEPTH)));

  // R10: backdrop only moves after a palette write
  assert_backdrop_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wreg == REG_PALETTE)) |=> $stable(backdrop));

endmodule

// File: tb/test_vmem_access_unit.sv
`timescale 1ns/100ps
module test_vmem_access_unit;
  localparam int VAW    = 12;
  localparam int PAW    = 10;
  localparam int OAW    = 10;
  localparam int VBYTES = 3 * (2 ** (VAW - 2));
  localparam int PBYTES = 2 ** PAW;
  localparam int OBYTES = 2 ** OAW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_region = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  bg_mode = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_region = '0;
  logic [1:0]  rd_size = '0;
  logic [31:0] rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [15:0] backdrop;

  vmem_access_unit #(.VID_AW(VAW), .PAL_AW(PAW), .OBJ_AW(OAW)) i_vmem_access_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_region(wr_region), .wr_size(wr_size),
    .wr_addr(wr_addr), .wr_data(wr_data), .bg_mode(bg_mode), .rd_en(rd_en),
    .rd_region(rd_region), .rd_size(rd_size), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .backdrop(backdrop)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] last_rd;

  logic [7:0] vm [VBYTES];
  logic [7:0] pm [PBYTES];
  logic [7:0] om [OBYTES];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int vmap(logic [31:0] a);
    int m;
    m = int'(a) & (2 ** VAW - 1);
    if (m >= VBYTES) m = 2 ** (VAW - 1) + (m & (2 ** (VAW - 2) - 1));
    return m;
  endfunction

  function automatic int idx_of(int r, logic [31:0] a);
    if (r == 0) return vmap(a);
    if (r == 1) return int'(a) & (PBYTES - 1);
    return int'(a) & (OBYTES - 1);
  endfunction

  function automatic logic [7:0] gb(int r, int i);
    if (r == 0) return vm[i];
    if (r == 1) return pm[i];
    return om[i];
  endfunction

  task automatic pb(input int r, input int i, input logic [7:0] v);
    if (r == 0) vm[i] = v;
    else if (r == 1) pm[i] = v;
    else om[i] = v;
  endtask

  function automatic logic [31:0] mread(int r, int sz, logic [31:0] a);
    int i, b;
    if (r == 3) return 32'h0;
    i = idx_of(r, a);
    if (sz == 0) return {24'h0, gb(r, i)};
    if (sz == 1) begin
      b = i & ~1;
      return {16'h0, gb(r, b + 1), gb(r, b)};
    end
    b = i & ~3;
    return {gb(r, b + 3), gb(r, b + 2), gb(r, b + 1), gb(r, b)};
  endfunction

  task automatic mwrite(input int r, input int sz, input logic [31:0] a, input logic [31:0] d, input int md);
    int i, b, lim;
    if (r == 3) return;
    i = idx_of(r, a);
    if (sz == 0) begin
      if (r == 2) return;
      lim = (md <= 2) ? 2 ** (VAW - 1) : 2 ** (VAW - 1) + 2 ** (VAW - 3);
      if (r == 0 && i >= lim) return;
      b = i & ~1;
      pb(r, b, d[7:0]);
      pb(r, b + 1, d[7:0]);
    end else if (sz == 1) begin
      b = i & ~1;
      pb(r, b, d[7:0]);
      pb(r, b + 1, d[15:8]);
    end else begin
      b = i & ~3;
      pb(r, b, d[7:0]);
      pb(r, b + 1, d[15:8]);
      pb(r, b + 2, d[23:16]);
      pb(r, b + 3, d[31:24]);
    end
  endtask

  // one cycle: drive at negedge, check at following negedge
  task automatic cyc(input bit w, input int wr_r, input int wsz, input logic [31:0] wa,
                     input logic [31:0] wd, input int md, input bit r, input int rr_r,
                     input int rsz, input logic [31:0] ra);
    logic [31:0] exp;
    exp = r ? mread(rr_r, rsz, ra) : 32'h0;
    if (w) mwrite(wr_r, wsz, wa, wd, md);
    wr_en = w; wr_region = 2'(wr_r); wr_size = 2'(wsz); wr_addr = wa; wr_data = wd;
    bg_mode = 3'(md);
    rd_en = r; rd_region = 2'(rr_r); rd_size = 2'(rsz); rd_addr = ra;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
    chk(rd_valid == r, "R2 rd_valid", 32'(rd_valid), 32'(r));
    if (r) chk(rd_data == exp, "R3 read data vs model", rd_data, exp);
    chk(backdrop == {pm[1], pm[0]}, "R10 backdrop", 32'(backdrop), {16'h0, pm[1], pm[0]});
    last_rd = rd_data;
  endtask

  task automatic wr(input int r, input int sz, input logic [31:0] a, input logic [31:0] d, input int md);
    cyc(1, r, sz, a, d, md, 0, 0, 0, 32'h0);
  endtask

  task automatic rd(input int r, input int sz, input logic [31:0] a);
    cyc(0, 0, 0, 32'h0, 32'h0, 0, 1, r, sz, a);
  endtask

  task automatic expect_rd(input string tag, input logic [31:0] exp);
    chk(last_rd == exp, tag, last_rd, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    for (int i = 0; i < VBYTES; i++) vm[i] = 8'h0;
    for (int i = 0; i < PBYTES; i++) pm[i] = 8'h0;
    for (int i = 0; i < OBYTES; i++) om[i] = 8'h0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "R1 rd_valid in reset", 32'(rd_valid), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", 32'(rd_valid), 32'h0);
    chk(backdrop == 16'h0, "R1 backdrop after reset", 32'(backdrop), 32'h0);

    // fill every array with word writes so later reads are defined
    for (int i = 0; i < VBYTES / 4; i++) wr(0, 2, 32'(i * 4), $urandom, 0);
    for (int i = 0; i < PBYTES / 4; i++) wr(1, 2, 32'(i * 4), $urandom, 0);
    for (int i = 0; i < OBYTES / 4; i++) wr(2, 2, 32'(i * 4), $urandom, 0);

    // R4: aliasing of the top quarter and high address bits
    wr(0, 2, 32'h0000_0810, 32'hA1B2C3D4, 0);
    rd(0, 2, 32'hFFFF_FC10);
    expect_rd("R4 alias read 0xC10 -> 0x810", 32'hA1B2C3D4);
    wr(0, 2, 32'h0000_1E04, 32'h11223344, 0);
    rd(0, 2, 32'h0000_0A04);
    expect_rd("R4 alias write 0xE04 -> 0xA04", 32'h11223344);

    // R5: palette and attribute windows
    wr(1, 2, 32'h0000_7404, 32'h55667788, 0);
    rd(1, 2, 32'h0000_0004);
    expect_rd("R5 palette low bits", 32'h55667788);
    wr(2, 2, 32'h0000_0BF8, 32'h0BADBEEF, 0);
    rd(2, 2, 32'h0000_03F8);
    expect_rd("R5 attribute low bits", 32'h0BADBEEF);

    // R6: byte duplication
    wr(1, 2, 32'h10, 32'h01020304, 0);
    wr(1, 0, 32'h13, 32'hFFFF_FF5A, 0);
    rd(1, 2, 32'h10);
    expect_rd("R6 palette byte dup", 32'h5A5A0304);
    wr(0, 2, 32'h100, 32'h0, 0);
    wr(0, 0, 32'h101, 32'h3C, 0);
    rd(0, 2, 32'h100);
    expect_rd("R6 video byte dup", 32'h00003C3C);

    // R7: attribute byte writes discarded, halfword stored
    wr(2, 2, 32'h40, 32'hCAFEF00D, 0);
    wr(2, 0, 32'h41, 32'h99, 0);
    rd(2, 2, 32'h40);
    expect_rd("R7 attribute byte ignored", 32'hCAFEF00D);
    wr(2, 1, 32'h42, 32'h1234, 0);
    rd(2, 2, 32'h40);
    expect_rd("R7 attribute halfword stored", 32'h1234F00D);

    // R8: mode-dependent video byte limit
    wr(0, 2, 32'h800, 32'h01020304, 0);
    wr(0, 0, 32'h801, 32'hEE, 0);
    rd(0, 2, 32'h800);
    expect_rd("R8 mode 0 byte at limit dropped", 32'h01020304);
    wr(0, 0, 32'h801, 32'hEE, 3);
    rd(0, 2, 32'h800);
    expect_rd("R8 mode 3 byte at 0x800 stored", 32'h0102EEEE);
    wr(0, 2, 32'h7FC, 32'h0, 2);
    wr(0, 0, 32'h7FF, 32'h77, 2);
    rd(0, 2, 32'h7FC);
    expect_rd("R8 mode 2 byte below limit stored", 32'h77770000);
    wr(0, 2, 32'hA00, 32'h0A0B0C0D, 3);
    wr(0, 0, 32'hA02, 32'hAB, 3);
    rd(0, 2, 32'hA00);
    expect_rd("R8 mode 3 byte at limit dropped", 32'h0A0B0C0D);
    wr(0, 0, 32'hE02, 32'hAB, 5);
    rd(0, 2, 32'hA00);
    expect_rd("R8 mode 5 aliased byte dropped", 32'h0A0B0C0D);
    wr(0, 2, 32'h9FC, 32'h0, 3);
    wr(0, 0, 32'h9FE, 32'hAB, 3);
    rd(0, 2, 32'h9FC);
    expect_rd("R8 mode 3 byte below limit stored", 32'hABAB0000);
    wr(0, 1, 32'hA02, 32'hBEEF, 0);
    rd(0, 2, 32'hA00);
    expect_rd("R8 halfword above limit stored", 32'hBEEF0C0D);

    // R9: same-cycle read and write
    wr(1, 2, 32'h20, 32'h11111111, 0);
    cyc(1, 1, 2, 32'h20, 32'h22222222, 0, 1, 1, 2, 32'h420);
    expect_rd("R9 collision returns old data", 32'h11111111);
    rd(1, 2, 32'h20);
    expect_rd("R9 write landed", 32'h22222222);

    // R10: backdrop
    wr(1, 0, 32'h1, 32'h7E, 0);
    chk(backdrop == 16'h7E7E, "R10 backdrop byte dup", 32'(backdrop), 32'h7E7E);
    wr(1, 2, 32'h400, 32'hDEAD1357, 0);
    chk(backdrop == 16'h1357, "R10 backdrop via alias", 32'(backdrop), 32'h1357);
    wr(1, 1, 32'h2, 32'hFFFF, 0);
    chk(backdrop == 16'h1357, "R10 backdrop untouched by byte 2", 32'(backdrop), 32'h1357);

    // R11 and R3: sizes and little-endian order
    wr(0, 2, 32'h30, 32'h0, 0);
    wr(0, 1, 32'h33, 32'h0000ABCD, 0);
    rd(0, 1, 32'h32);
    expect_rd("R11 halfword write/read", 32'h0000ABCD);
    rd(0, 0, 32'h33);
    expect_rd("R3 byte read upper lane", 32'h000000AB);
    rd(0, 2, 32'h31);
    expect_rd("R11 word read ignores low bits", 32'hABCD0000);
    wr(0, 3, 32'h44, 32'h87654321, 0);
    rd(0, 2, 32'h44);
    expect_rd("R3 size 3 acts as word", 32'h87654321);
    rd(0, 0, 32'h45);
    expect_rd("R3 byte read lane 1", 32'h00000043);
    rd(3, 2, 32'h44);
    expect_rd("R3 region 3 reads zero", 32'h0);

    // random traffic with collisions
    for (int n = 0; n < 3000; n++) begin
      int wrr, wsz, rrr, rsz, md;
      bit w, r;
      logic [31:0] wa, ra;
      w   = ($urandom % 2) == 0;
      r   = ($urandom % 5) < 3;
      wrr = int'($urandom % 4);
      wsz = int'($urandom % 4);
      rsz = int'($urandom % 4);
      md  = int'($urandom % 8);
      wa  = $urandom;
      if (($urandom % 4) == 0) begin
        rrr = wrr;
        ra  = wa;
      end else begin
        rrr = int'($urandom % 4);
        ra  = $urandom;
      end
      cyc(w, wrr, wsz, wa, $urandom, md, r, rrr, rsz, ra);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule